// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command for a synchronous DRAM bank into a run of column addresses, one per clock. The command carries a starting column, a burst-length choice (4 or 8 beats) and an ordering choice. Every beat address stays inside the aligned power-of-two group of columns that holds the starting column. Only the low bits change. They step either by a wrapping increment or by an exclusive-or with the beat number.

For reads, the block also delays a valid strobe, together with the beat's column and last flag, by a programmable CAS latency of 2 to 6 cycles. A shift pipeline carries these tags. The issue stage becomes free on the last beat of a burst, so the next command can be taken while earlier read beats are still waiting in the pipeline. Consecutive bursts then follow each other with no idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_valid` and `rd_valid` are 0 and `cmd_ready` is 1.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both 1 at a rising edge. Its first beat appears in the next cycle with `beat_col` equal to `cmd_col` and `beat_idx` 0. The remaining beats follow in consecutive cycles with `beat_idx` counting up by one. `beat_last` is 1 only on the final beat.
- R3: With `cmd_interleave`=0 (sequential), the low n bits of beat i equal (start low bits + i) mod 2^n. The column bits above them equal those of the start.
- R4: With `cmd_interleave`=1 (interleaved), the low n bits of beat i equal the start's low n bits XOR i. The column bits above them equal those of the start.
- R5: When the start column's low n bits are zero, both orderings give ascending columns start, start+1, and so on.
- R6: `cmd_bl8`=0 selects 4 beats with n=2. `cmd_bl8`=1 selects 8 beats with n=3, and `beat_idx` runs from 0 to 7.
- R7: `cmd_ready` is 0 while beats other than the last are still to be issued, and 1 during the last beat and when idle. A `cmd_valid` seen while `cmd_ready` is 0 is ignored. A command accepted during a last beat starts in the very next cycle.
- R8: For a read burst, each beat issued in cycle t gives `rd_valid`=1 in cycle t+`cas_lat`, with `rd_col` and `rd_last` equal to that beat's `beat_col` and `beat_last`. Write bursts never raise `rd_valid`.
- R9: A command accepted while earlier read beats are still inside the latency window does not change those beats' delayed column, last flag or timing.
- R10: `cas_lat` takes values from 2 to 6. It must stay constant from the acceptance of a read until its last delayed beat has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Issue stage can take a command |
| cmd_read | input | 1 | 1 = read burst, 0 = write burst |
| cmd_col | input | COL_W | Starting column |
| cmd_bl8 | input | 1 | 1 = 8 beats, 0 = 4 beats |
| cmd_interleave | input | 1 | 1 = XOR ordering, 0 = wrapping increment |
| cas_lat | input | CL_W | Read latency in cycles (2..6) |
| beat_valid | output | 1 | A column address is issued this cycle |
| beat_col | output | COL_W | Issued column address |
| beat_idx | output | 3 | Beat number within the burst |
| beat_last | output | 1 | Final beat of the burst |
| rd_valid | output | 1 | Delayed read-data valid |
| rd_col | output | COL_W | Column belonging to the delayed read beat |
| rd_last | output | 1 | Delayed beat is the last of its read burst |

## Verification
The bench uses the default parameters: 10-bit columns and a pipeline 6 stages deep. With these values the full latency range can be reached, including the deepest stage, where a read still waits while the next burst is issued. Phases at latencies 2, 6 and 4 exercise the shortest tap, the longest tap and a middle one. A random phase places starting columns at every offset inside 4- and 8-column blocks and also near the top of the column space, where the upper bits must stay unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MIN_CL = 2;
  localparam int ORD_W  = 3;   // widest ordering field (8 beats)

  typedef enum logic { ORD_SEQ = 1'b0, ORD_ILV = 1'b1 } order_e;

  // Low-bit beat ordering inside the aligned block.
  function automatic logic [ORD_W-1:0] low_order(logic [ORD_W-1:0] start_low,
                                                 logic [ORD_W-1:0] beat,
                                                 logic bl8, order_e ord);
    logic [ORD_W-1:0] mask, mixed;
    mask  = bl8 ? 3'b111 : 3'b011;
    mixed = (ord == ORD_ILV) ? (start_low ^ beat) : (start_low + beat);
    return (start_low & ~mask) | (mixed & mask);
  endfunction
endpackage

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  input  order_e           cmd_ord,
  input  logic             cmd_rd,
  output logic             busy,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic [2:0]       beat_idx,
  output logic             beat_last,
  output logic             beat_rd
);
  localparam int HI_W = COL_W - ORD_W;

  function automatic logic [COL_W-1:0] col_at(logic [COL_W-1:0] base, logic [2:0] beat,
                                              logic bl8, order_e ord);
    return {base[COL_W-1:ORD_W], low_order(base[ORD_W-1:0], beat, bl8, ord)};
  endfunction

  logic             act;
  logic [COL_W-1:0] st_col;
  logic             st_bl8;
  order_e           st_ord;
  logic             st_rd;
  logic [2:0]       cnt;
  logic [2:0]       nxt;
  logic             nxt_last;   // named event: final beat about to issue

  assign nxt      = cnt + 3'd1;
  assign nxt_last = (nxt == (st_bl8 ? 3'd7 : 3'd3));
  assign busy     = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; st_col <= '0; st_bl8 <= 1'b0; st_ord <= ORD_SEQ; st_rd <= 1'b0;
      cnt <= '0; beat_valid <= 1'b0; beat_col <= '0; beat_idx <= '0;
      beat_last <= 1'b0; beat_rd <= 1'b0;
    end else if (accept) begin
      st_col <= cmd_col; st_bl8 <= cmd_bl8; st_ord <= cmd_ord; st_rd <= cmd_rd;
      cnt <= '0; act <= 1'b1;
      beat_valid <= 1'b1;
      beat_col   <= col_at(cmd_col, 3'd0, cmd_bl8, cmd_ord);
      beat_idx   <= 3'd0;
      beat_last  <= 1'b0;
      beat_rd    <= cmd_rd;
    end else if (act) begin
      cnt        <= nxt;
      act        <= !nxt_last;
      beat_valid <= 1'b1;
      beat_col   <= col_at(st_col, nxt, st_bl8, st_ord);
      beat_idx   <= nxt;
      beat_last  <= nxt_last;
      beat_rd    <= st_rd;
    end else begin
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_rd    <= 1'b0;
    end
  end

  logic [HI_W:0] blk_out, blk_st;
  assign blk_out = st_bl8 ? {1'b0, beat_col[COL_W-1:3]} : beat_col[COL_W-1:2];
  assign blk_st  = st_bl8 ? {1'b0, st_col[COL_W-1:3]}   : st_col[COL_W-1:2];

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_valid && beat_idx == $past(beat_idx) + 3'd1));
  // R6
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> (beat_valid && beat_idx == (st_bl8 ? 3'd7 : 3'd3)));
  // R3
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (blk_out == blk_st));
endmodule

// File: rtl/bcs_rd_pipe.sv
module bcs_rd_pipe
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_CL = 6,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_last,
  input  logic [CL_W-1:0]  cas_lat,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col,
  output logic             rd_last
);
  logic [MAX_CL-1:0] sv, sl;
  logic [COL_W-1:0]  sc [MAX_CL];
  logic [CL_W-1:0]   sel;
  logic              lat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv[0] <= 1'b0; sl[0] <= 1'b0; sc[0] <= '0;
    end else begin
      sv[0] <= in_v; sl[0] <= in_v & in_last; sc[0] <= in_col;
    end
  end

  for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv[i] <= 1'b0; sl[i] <= 1'b0; sc[i] <= '0;
      end else begin
        sv[i] <= sv[i-1]; sl[i] <= sl[i-1]; sc[i] <= sc[i-1];
      end
    end
  end

  assign lat_ok = (cas_lat >= CL_W'(MIN_CL)) && (cas_lat <= CL_W'(MAX_CL));
  assign sel    = lat_ok ? cas_lat - CL_W'(1) : '0;

  always_comb begin
    rd_valid = 1'b0; rd_last = 1'b0; rd_col = '0;
    for (int k = 0; k < MAX_CL; k++) begin
      if (sel == CL_W'(k)) begin
        rd_valid = sv[k] & lat_ok; rd_last = sl[k] & lat_ok; rd_col = sc[k];
      end
    end
  end

  // R10
  cas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |-> lat_ok);
  // R8
  rd_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_CL = 6,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  input  logic             cmd_interleave,
  input  logic [CL_W-1:0]  cas_lat,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic [2:0]       beat_idx,
  output logic             beat_last,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col,
  output logic             rd_last
);
  logic accept, busy, beat_rd, rd_issue;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid & cmd_ready;
  assign rd_issue  = beat_valid & beat_rd;

  bcs_beat_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_col(cmd_col),
    .cmd_bl8(cmd_bl8), .cmd_ord(cmd_interleave ? ORD_ILV : ORD_SEQ),
    .cmd_rd(cmd_read), .busy(busy), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_idx(beat_idx), .beat_last(beat_last),
    .beat_rd(beat_rd)
  );

  bcs_rd_pipe #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(rd_issue), .in_col(beat_col),
    .in_last(beat_last), .cas_lat(cas_lat), .rd_valid(rd_valid),
    .rd_col(rd_col), .rd_last(rd_last)
  );

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> !cmd_ready);
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_bl8 = 1'b0, cmd_interleave = 1'b0;
  logic [9:0] cmd_col = '0;
  logic [2:0] cas_lat = 3'd2;
  logic cmd_ready, beat_valid, beat_last, rd_valid, rd_last;
  logic [9:0] beat_col, rd_col;
  logic [2:0] beat_idx;

  always #2 clk = ~clk;   // 250 MHz

  burst_col_seq u_burst_col_seq (.*);

  typedef struct { int col; int idx; bit last; bit rd; string ctag; string itag; } beat_t;
  typedef struct { int col; bit rd; bit bl8; bit ilv; int gap; } cmd_t;

  beat_t pend[$];
  beat_t hist[int];
  cmd_t  cmds[$];
  int checks = 0, errors = 0, cyc = 0, gap = 0, cl = 2;
  string rdtag = "R8";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic add(int col, bit rd, bit bl8, bit ilv, int g);
    cmd_t c;
    c.col = col; c.rd = rd; c.bl8 = bl8; c.ilv = ilv; c.gap = g;
    cmds.push_back(c);
  endtask

  task automatic push_beats(cmd_t c);
    int blen = c.bl8 ? 8 : 4;
    int base = c.col - (c.col % blen);
    int off  = c.col % blen;
    for (int i = 0; i < blen; i++) begin
      beat_t b;
      b.col  = c.ilv ? base + (off ^ i) : base + ((off + i) % blen);
      b.idx  = i; b.last = (i == blen - 1); b.rd = c.rd;
      b.ctag = (off == 0) ? "R5" : (c.ilv ? "R4" : "R3");
      b.itag = c.bl8 ? "R6" : "R2";
      pend.push_back(b);
    end
  endtask

  task automatic step();
    bit exp_ready;
    @(negedge clk);
    cyc++;
    if (pend.size() > 0) begin
      beat_t e = pend.pop_front();
      chk(e.itag, "beat_valid", int'(beat_valid), 1);
      chk(e.ctag, "beat_col", int'(beat_col), e.col);
      chk(e.itag, "beat_idx", int'(beat_idx), e.idx);
      chk(e.itag, "beat_last", int'(beat_last), int'(e.last));
      hist[cyc] = e;
    end else begin
      chk("R2", "beat_valid idle", int'(beat_valid), 0);
    end
    if (hist.exists(cyc - cl) && hist[cyc - cl].rd) begin
      chk(rdtag, "rd_valid", int'(rd_valid), 1);
      chk(rdtag, "rd_col", int'(rd_col), hist[cyc - cl].col);
      chk(rdtag, "rd_last", int'(rd_last), int'(hist[cyc - cl].last));
    end else begin
      chk("R8", "rd_valid none", int'(rd_valid), 0);
    end
    exp_ready = (pend.size() == 0);
    chk("R7", "cmd_ready", int'(cmd_ready), int'(exp_ready));
    // drive inputs for the coming edge
    if (gap > 0) begin
      gap--; cmd_valid = 1'b0;
    end else if (cmds.size() > 0) begin
      cmd_t c = cmds[0];
      cmd_valid = 1'b1; cmd_col = 10'(c.col); cmd_read = c.rd;
      cmd_bl8 = c.bl8; cmd_interleave = c.ilv;
      if (exp_ready) begin
        void'(cmds.pop_front());
        push_beats(c);
        gap = c.gap;
      end
      // when not ready, the held command must be ignored (R7)
    end else begin
      cmd_valid = 1'b0;
    end
  endtask

  task automatic run_phase(int lat, string tag);
    cl = lat; cas_lat = 3'(lat); rdtag = tag;
    while (cmds.size() > 0 || pend.size() > 0 || gap > 0) step();
    repeat (8) step();
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1", "beat_valid in reset", int'(beat_valid), 0);
      chk("R1", "rd_valid in reset", int'(rd_valid), 0);
      chk("R1", "cmd_ready in reset", int'(cmd_ready), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "beat_valid after reset", int'(beat_valid), 0);
    chk("R1", "cmd_ready after reset", int'(cmd_ready), 1);

    // Phase A: shortest latency, 4-beat bursts, every ordering
    add(8, 1, 0, 0, 0);  add(8, 1, 0, 1, 3);     // R5 aligned
    add(13, 1, 0, 0, 0); add(13, 1, 0, 1, 0);    // R3, R4 back to back
    add(14, 0, 0, 1, 2); add(1023, 1, 0, 0, 0);  // write, top of space
    run_phase(2, "R8");

    // Phase B: longest latency, 8-beat bursts overlapping in the pipeline
    add(37, 1, 1, 0, 0); add(46, 1, 1, 1, 0);    // R6 with R3 / R4
    add(64, 1, 1, 0, 0); add(64, 1, 1, 1, 0);    // R5 aligned
    add(5, 1, 0, 1, 0);  add(1021, 0, 1, 0, 0);
    run_phase(6, "R9");

    // Phase C: middle latency, mixed random traffic
    for (int n = 0; n < 40; n++)
      add(int'($urandom % 1024), bit'($urandom % 2), bit'($urandom % 2),
          bit'($urandom % 2), int'($urandom % 3));
    run_phase(4, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule